// File: doc/BRIEF.md
# Packet-Framed I2C Master Front End

This block turns a stream of 32-bit words into complete I2C master transfers. Software, or an upstream agent, pushes three header words into a transmit FIFO and then any payload words. The block reads the headers to learn the target address, the direction, the byte count and how to close the bus. It then issues a sequence of byte-level commands to an I2C byte engine. Payload moves as packed little-endian words: bytes to write are taken from transmit words, and bytes that are read are gathered into words in a receive FIFO.

The transmit side is a valid/ready stream. `tx_ready` is high while a slot is free. A producer should hold `tx_valid` and `tx_data` until it sees `tx_ready`. A word offered while `tx_ready` is low is dropped, and the drop is recorded in a sticky overflow bit. The receive side is also a valid/ready stream. A word is consumed on any cycle where both `rx_valid` and `rx_ready` are high. A full receive FIFO stalls further reads on the bus. The byte engine link carries one command at a time: the command is held until it is accepted, and the block then waits for its single response.

The block reports its state through two occupancy counts and a write-one-to-clear interrupt status vector. A soft reset flushes both FIFOs and the transfer sequencer but keeps the status bits, so the cause of an error can still be read afterwards.

Top module: `pkt_i2c_front`

## Requirements
- R1: A transfer starts with three header words taken from the transmit FIFO in order. The contents of the first word are ignored. The second word holds a size field in bits [11:0]. The third word holds a 7-bit address in bits [6:0], a read flag in bit 16 and a repeated-start flag in bit 17. The first engine command is START (cmd_op 0), and its byte is {address, read flag}.
- R2: The size field is the byte count minus one, so 0 transfers exactly one byte and 4095 transfers 4096 bytes.
- R3: For a write, each payload byte is sent as a WRITE command (cmd_op 1). Bytes are taken lowest lane first from each transmit word, and ceil(count/4) words are consumed. Unused upper lanes of the final word are never sent.
- R4: For a read, each byte is fetched with a READ command (cmd_op 2), and cmd_last is high only on the final byte. Bytes fill receive words lowest lane first, and the unused upper lanes of the final word read as zero. A full receive FIFO stalls the next READ until a word is popped.
- R5: After the last payload byte, the block sends STOP (cmd_op 3) when the repeated-start flag is clear and REPEATED START (cmd_op 4) when it is set.
- R6: `tx_free` reports the number of empty transmit slots (8 when drained), and `rx_count` reports the number of filled receive words.
- R7: A transmit word offered while `tx_ready` is low is dropped without disturbing the queued words, and it sets sticky status bit 3.
- R8: With the receive FIFO empty, `rx_valid` is low and `rx_data` is zero, and `rx_ready` has no effect.
- R9: Status bits are done (bit 0), no-acknowledge (bit 1), arbitration lost (bit 2) and overflow (bit 3). A clear strobe clears exactly the bits that are one in `irq_clr_data`.
- R10: A no-acknowledge on an address or write byte sets bit 1, and lost arbitration on any command sets bit 2. Either one halts the sequencer: no further engine commands are issued and no transmit words are taken.
- R11: The done bit is set only when the closing STOP or REPEATED START has been acknowledged, and never for a transfer that ended in error.
- R12: A soft reset returns the sequencer to idle, empties both FIFOs (`tx_free` 8, `rx_count` 0) and keeps the status bits. A new transfer then runs normally.
- R13: An engine command is held with the same op and byte until `cmd_ready`, and at most one command is outstanding until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_reset | input | 1 | Synchronous flush of FIFOs and sequencer |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO has a free slot |
| tx_data | input | 32 | Transmit word (header or payload) |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Consumer takes the receive word |
| rx_data | output | 32 | Receive word, zero when empty |
| tx_free | output | 4 | Empty transmit slots |
| rx_count | output | 4 | Filled receive words |
| irq_status | output | 4 | Status: done, nack, arbitration lost, overflow |
| irq_clr_valid | input | 1 | Clear strobe |
| irq_clr_data | input | 4 | Bits to clear |
| cmd_valid | output | 1 | Engine command valid |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 3 | 0 START, 1 WRITE, 2 READ, 3 STOP, 4 REPEATED START |
| cmd_byte | output | 8 | Address byte or write data |
| cmd_last | output | 1 | Final payload byte of the transfer |
| rsp_valid | input | 1 | Engine response |
| rsp_nack | input | 1 | Target did not acknowledge |
| rsp_arb | input | 1 | Arbitration lost |
| rsp_data | input | 8 | Byte read from the bus |

## Verification
The bench sends a write whose final word has junk in its upper lanes. A block that ignored the remainder would emit extra WRITE commands. It reads five bytes, which checks lane order and that the upper lanes of the final word are zero. It also reads forty bytes, which forces the receive FIFO full: a design that ignored back-pressure would lose words or keep reading. A one-byte transfer exposes an off-by-one in the size field. The bench injects no-acknowledge and lost arbitration and then looks for a halted sequencer and a clean soft reset. It also stalls the engine, fills the transmit FIFO and pushes once more, to catch an overflow that corrupts queued data or never sets the sticky bit.

// File: rtl/pkt_i2c_pkg.sv
package pkt_i2c_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 12;
  localparam int ADDR_W   = 7;
  localparam int RD_BIT   = 16;
  localparam int RS_BIT   = 17;
  localparam int IRQ_W    = 4;
  localparam int IRQ_DONE = 0;
  localparam int IRQ_NACK = 1;
  localparam int IRQ_ARB  = 2;
  localparam int IRQ_OVF  = 3;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_WRITE  = 3'd1,
    OP_READ   = 3'd2,
    OP_STOP   = 3'd3,
    OP_RSTART = 3'd4
  } eng_op_e;
endpackage

// File: rtl/pkt_i2c_fifo.sv
module pkt_i2c_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7: a push on a full FIFO leaves the count unchanged unless a pop happens
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (full && push && !pop) |=> count == CW'(DEPTH));
endmodule

// File: rtl/pkt_i2c_seq.sv
module pkt_i2c_seq
  import pkt_i2c_pkg::*;
#(
  localparam int LW = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_last,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic              rsp_arb,
  input  logic [7:0]        rsp_data,
  output logic              done_p,
  output logic              nack_p,
  output logic              arb_p
);
  typedef enum logic [3:0] {
    S_H1, S_H2, S_H3, S_ADDR, S_FETCH, S_WBYTE, S_RBYTE, S_RPUSH, S_END, S_HALT
  } st_e;

  st_e               st;
  logic              rd_mode, rs_flag, wait_rsp, issue, got_rsp, rsp_ok, nack_ok_state;
  logic [ADDR_W-1:0] addr;
  logic [LW-1:0]     left;
  logic [1:0]        lane;
  logic [WORD_W-1:0] wbuf, rbuf;
  eng_op_e           op_sel;

  assign issue     = (st == S_ADDR) || (st == S_WBYTE) || (st == S_RBYTE) || (st == S_END);
  assign cmd_valid = issue && !wait_rsp;
  assign cmd_last  = (left == LW'(1));
  assign tx_pop    = !tx_empty && ((st == S_H1) || (st == S_H2) || (st == S_H3) || (st == S_FETCH));
  assign rx_push   = (st == S_RPUSH) && !rx_full;
  assign rx_word   = rbuf;

  always_comb begin
    unique case (st)
      S_ADDR:  op_sel = OP_START;
      S_WBYTE: op_sel = OP_WRITE;
      S_RBYTE: op_sel = OP_READ;
      default: op_sel = rs_flag ? OP_RSTART : OP_STOP;
    endcase
  end
  assign cmd_op   = op_sel;
  assign cmd_byte = (st == S_ADDR)  ? {addr, rd_mode} :
                    (st == S_WBYTE) ? wbuf[{lane, 3'b000} +: 8] : 8'h00;

  assign nack_ok_state = (st == S_ADDR) || (st == S_WBYTE);
  assign got_rsp = wait_rsp && rsp_valid;
  assign arb_p   = got_rsp && rsp_arb;
  assign nack_p  = got_rsp && !rsp_arb && rsp_nack && nack_ok_state;
  assign rsp_ok  = got_rsp && !arb_p && !nack_p;
  assign done_p  = rsp_ok && (st == S_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_H1; rd_mode <= 1'b0; rs_flag <= 1'b0; wait_rsp <= 1'b0;
      addr <= '0; left <= '0; lane <= '0; wbuf <= '0; rbuf <= '0;
    end else if (flush) begin
      st <= S_H1; rd_mode <= 1'b0; rs_flag <= 1'b0; wait_rsp <= 1'b0;
      addr <= '0; left <= '0; lane <= '0; wbuf <= '0; rbuf <= '0;
    end else begin
      if (cmd_valid && cmd_ready) wait_rsp <= 1'b1;
      if (got_rsp)                wait_rsp <= 1'b0;
      if (arb_p || nack_p) begin
        st <= S_HALT;
      end else begin
        unique case (st)
          S_H1: if (tx_pop) st <= S_H2;
          S_H2: if (tx_pop) begin
            left <= {1'b0, tx_word[LEN_W-1:0]} + LW'(1);
            st   <= S_H3;
          end
          S_H3: if (tx_pop) begin
            addr    <= tx_word[ADDR_W-1:0];
            rd_mode <= tx_word[RD_BIT];
            rs_flag <= tx_word[RS_BIT];
            st      <= S_ADDR;
          end
          S_ADDR: if (rsp_ok) begin
            lane <= '0;
            rbuf <= '0;
            st   <= rd_mode ? S_RBYTE : S_FETCH;
          end
          S_FETCH: if (tx_pop) begin
            wbuf <= tx_word;
            st   <= S_WBYTE;
          end
          S_WBYTE: if (rsp_ok) begin
            left <= left - 1'b1;
            lane <= lane + 1'b1;
            if (left == LW'(1))      st <= S_END;
            else if (lane == 2'd3)   st <= S_FETCH;
          end
          S_RBYTE: if (rsp_ok) begin
            rbuf[{lane, 3'b000} +: 8] <= rsp_data;
            left <= left - 1'b1;
            lane <= lane + 1'b1;
            if (lane == 2'd3 || left == LW'(1)) st <= S_RPUSH;
          end
          S_RPUSH: if (rx_push) begin
            rbuf <= '0;
            st   <= (left == '0) ? S_END : S_RBYTE;
          end
          S_END:  if (rsp_ok) st <= S_H1;
          default: st <= S_HALT;
        endcase
      end
    end
  end

  // R13: a command waiting for acceptance keeps its op and byte
  a_r13_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));
  // R13: no new command while a response is owed
  a_r13_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (cmd_valid && cmd_ready) |=> !cmd_valid);
  // R10: an error halts commands and transmit consumption
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (nack_p || arb_p) |=> (!cmd_valid && !tx_pop));
  // R4: nothing is pushed into a full receive FIFO
  a_r4_rx_stall: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (st == S_RPUSH && rx_full) |=> (st == S_RPUSH && !cmd_valid));
endmodule

// File: rtl/pkt_i2c_front.sv
module pkt_i2c_front
  import pkt_i2c_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic [CW-1:0]     tx_free,
  output logic [CW-1:0]     rx_count,
  output logic [IRQ_W-1:0]  irq_status,
  input  logic              irq_clr_valid,
  input  logic [IRQ_W-1:0]  irq_clr_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_last,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic              rsp_arb,
  input  logic [7:0]        rsp_data
);
  logic              tx_full, tx_empty, tx_pop;
  logic              rx_full, rx_empty, rx_push, rx_pop;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0]     tx_cnt;
  logic              done_p, nack_p, arb_p, ovf_p;
  logic [IRQ_W-1:0]  set_vec, clr_vec;

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign rx_pop   = rx_ready && rx_valid;
  assign rx_data  = rx_valid ? rx_head : '0;
  assign tx_free  = CW'(DEPTH) - tx_cnt;
  assign ovf_p    = tx_valid && tx_full;

  pkt_i2c_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(soft_reset),
    .push(tx_valid && tx_ready), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  pkt_i2c_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(soft_reset),
    .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

  pkt_i2c_seq u_seq (
    .clk(clk), .rst_n(rst_n), .flush(soft_reset),
    .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_arb(rsp_arb), .rsp_data(rsp_data),
    .done_p(done_p), .nack_p(nack_p), .arb_p(arb_p));

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_DONE] = done_p;
    set_vec[IRQ_NACK] = nack_p;
    set_vec[IRQ_ARB]  = arb_p;
    set_vec[IRQ_OVF]  = ovf_p;
  end
  assign clr_vec = irq_clr_valid ? irq_clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_status <= '0;
    else        irq_status <= (irq_status & ~clr_vec) | set_vec;
  end

  // R9: with no new event, a clear strobe leaves none of the named bits set
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_valid && set_vec == '0) |=> ((irq_status & $past(irq_clr_data)) == '0));
  // R7: an offered word that is refused raises the overflow bit
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> irq_status[IRQ_OVF]);
  // R12: soft reset leaves both queues empty and the engine link quiet
  a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (tx_free == CW'(DEPTH) && rx_count == '0 && !cmd_valid));
  // R11: done and an error are never raised together
  a_r11_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[IRQ_DONE]) |-> !$past(nack_p || arb_p));
endmodule

// File: tb/pkt_i2c_front_test.sv
module pkt_i2c_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_reset = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic [3:0]  tx_free, rx_count, irq_status;
  logic        irq_clr_valid = 1'b0;
  logic [3:0]  irq_clr_data = '0;
  logic        cmd_valid, cmd_ready, cmd_last;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_arb = 1'b0;
  logic [7:0]  rsp_data = '0;

  int checks = 0, failures = 0;
  int cyc = 0;

  // engine model state
  logic       eng_hold = 1'b0;
  logic       resp_pend = 1'b0;
  logic       nx_nack = 1'b0, nx_arb = 1'b0;
  logic [7:0] nx_data = '0;
  int         log_n = 0, rd_n = 0, err_idx = -1, err_kind = 0;
  logic [2:0] log_op   [64];
  logic [7:0] log_byte [64];
  logic       log_last [64];
  logic [3:0] log_irq  [64];

  assign cmd_ready = !eng_hold;

  pkt_i2c_front uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (resp_pend) begin
      rsp_valid = 1'b1; rsp_nack = nx_nack; rsp_arb = nx_arb; rsp_data = nx_data;
      resp_pend = 1'b0;
    end else begin
      rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_arb = 1'b0; rsp_data = 8'h00;
    end
    if (cmd_valid && cmd_ready && !rsp_valid) begin
      if (log_n < 64) begin
        log_op[log_n] = cmd_op; log_byte[log_n] = cmd_byte;
        log_last[log_n] = cmd_last; log_irq[log_n] = irq_status;
      end
      nx_nack = (log_n == err_idx) && (err_kind == 1);
      nx_arb  = (log_n == err_idx) && (err_kind == 2);
      nx_data = 8'h00;
      if (cmd_op == 3'd2) begin nx_data = 8'(8'h10 + rd_n); rd_n = rd_n + 1; end
      log_n = log_n + 1;
      resp_pend = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0; rd_n = 0; err_idx = -1; err_kind = 0;
  endtask

  task automatic push(input logic [31:0] w);
    int t = 0;
    while (!tx_ready && t < 2000) begin @(negedge clk); t++; end
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic push_raw(input logic [31:0] w);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_irq(input logic [3:0] mask);
    int t = 0;
    while ((irq_status & mask) == 0 && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_irq(input logic [3:0] m);
    irq_clr_valid = 1'b1; irq_clr_data = m;
    @(negedge clk);
    irq_clr_valid = 1'b0; irq_clr_data = '0;
    @(negedge clk);
  endtask

  task automatic pop_check(input string req, input logic [31:0] exp);
    int t = 0;
    while (!rx_valid && t < 2000) begin @(negedge clk); t++; end
    check(req, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic do_soft_reset();
    soft_reset = 1'b1;
    @(negedge clk);
    soft_reset = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pack4(input logic [7:0] b);
    return {8'(b + 3), 8'(b + 2), 8'(b + 1), b};
  endfunction

  task automatic t_reset();
    check("R6 reset tx_free", 32'(tx_free), 32'd8);
    check("R6 reset rx_count", 32'(rx_count), 32'd0);
    check("R9 reset irq", 32'(irq_status), 32'd0);
    check("R8 reset rx_valid", 32'(rx_valid), 32'd0);
    check("R8 reset rx_data", rx_data, 32'd0);
    check("R13 reset cmd_valid", 32'(cmd_valid), 32'd0);
  endtask

  task automatic t_write6();
    clear_log();
    push(32'h1001_0100); push(32'd5); push(32'h0000_0050);
    push(32'h4433_2211); push(32'hDEAD_6655);
    wait_irq(4'b0111);
    check("R11 write done", 32'(irq_status), 32'h1);
    check("R3 cmd count", log_n, 8);
    check("R1 start op", 32'(log_op[0]), 32'd0);
    check("R1 address byte", 32'(log_byte[0]), 32'hA0);
    for (int i = 1; i <= 6; i++) begin
      check("R3 write op", 32'(log_op[i]), 32'd1);
      check("R3 write byte", 32'(log_byte[i]), 32'(8'(8'h11 * i)));
    end
    check("R5 stop op", 32'(log_op[7]), 32'd3);
    check("R11 done not early", 32'(log_irq[7][0]), 32'd0);
    check("R6 tx drained", 32'(tx_free), 32'd8);
  endtask

  task automatic t_w1c();
    clr_irq(4'b0000);
    check("R9 zero clear keeps bit", 32'(irq_status), 32'h1);
    clr_irq(4'b0001);
    check("R9 clear bit0", 32'(irq_status), 32'h0);
  endtask

  task automatic t_read5_rs();
    clear_log();
    push(32'h0); push(32'd4); push(32'h0003_003C);
    wait_irq(4'b0111);
    check("R11 read done", 32'(irq_status), 32'h1);
    check("R4 cmd count", log_n, 7);
    check("R1 read address byte", 32'(log_byte[0]), 32'h79);
    check("R4 read op", 32'(log_op[3]), 32'd2);
    check("R4 last flag off", 32'(log_last[1]), 32'd0);
    check("R4 last flag on", 32'(log_last[5]), 32'd1);
    check("R5 repeated start op", 32'(log_op[6]), 32'd4);
    check("R6 rx_count", 32'(rx_count), 32'd2);
    pop_check("R4 word0", 32'h1312_1110);
    pop_check("R4 word1 upper lanes zero", 32'h0000_0014);
    check("R8 empty rx_valid", 32'(rx_valid), 32'd0);
    check("R8 empty rx_data", rx_data, 32'd0);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    check("R8 pop on empty no effect", 32'(rx_count), 32'd0);
    clr_irq(4'hF);
  endtask

  task automatic t_one_byte();
    clear_log();
    push(32'h0); push(32'd0); push(32'h0000_0021); push(32'hFFFF_FFAB);
    wait_irq(4'b0111);
    check("R2 one byte count", log_n, 3);
    check("R2 one byte data", 32'(log_byte[1]), 32'hAB);
    check("R2 one byte done", 32'(irq_status), 32'h1);
    clr_irq(4'hF);
  endtask

  task automatic t_nack();
    clear_log(); err_idx = 0; err_kind = 1;
    push(32'h0); push(32'd1); push(32'h0000_0011); push(32'h0000_2233);
    wait_irq(4'b0111);
    idle(20);
    check("R10 nack bit only", 32'(irq_status), 32'h2);
    check("R10 halted commands", log_n, 1);
    check("R10 payload left queued", 32'(tx_free), 32'd7);
    do_soft_reset();
    check("R12 tx flushed", 32'(tx_free), 32'd8);
    check("R12 status kept", 32'(irq_status), 32'h2);
    clr_irq(4'hF);
    clear_log();
    push(32'h0); push(32'd0); push(32'h0000_0021); push(32'h0000_005A);
    wait_irq(4'b0111);
    check("R12 runs after reset", 32'(irq_status), 32'h1);
    check("R12 fresh cmd count", log_n, 3);
    clr_irq(4'hF);
  endtask

  task automatic t_arb();
    clear_log(); err_idx = 2; err_kind = 2;
    push(32'h0); push(32'd3); push(32'h0000_0012); push(32'h0403_0201);
    wait_irq(4'b0111);
    idle(20);
    check("R10 arb bit", 32'(irq_status), 32'h4);
    check("R11 no done on error", 32'(irq_status[0]), 32'd0);
    check("R10 arb halt count", log_n, 3);
    do_soft_reset();
    clr_irq(4'hF);
  endtask

  task automatic t_overflow();
    int bad = 0;
    clear_log(); eng_hold = 1'b1;
    push(32'h0); push(32'd31); push(32'h0000_0005);
    idle(6);
    check("R6 headers consumed", 32'(tx_free), 32'd8);
    for (int i = 0; i < 8; i++) push(pack4(8'(4 * i)));
    check("R6 tx full free count", 32'(tx_free), 32'd0);
    check("R7 ready low when full", 32'(tx_ready), 32'd0);
    push_raw(32'hFFFF_FFFF);
    check("R7 overflow bit", 32'(irq_status[3]), 32'd1);
    eng_hold = 1'b0;
    wait_irq(4'b0111);
    check("R7 cmd count", log_n, 34);
    for (int i = 1; i <= 32; i++) if (log_byte[i] != 8'(i - 1)) bad++;
    check("R7 queued data intact", bad, 0);
    check("R7 last byte not dropped word", 32'(log_byte[32]), 32'h1F);
    clr_irq(4'hF);
  endtask

  task automatic t_rx_backpressure();
    clear_log();
    push(32'h0); push(32'd39); push(32'h0001_0060);
    idle(400);
    check("R4 rx fifo full", 32'(rx_count), 32'd8);
    check("R4 stalled no done", 32'(irq_status[0]), 32'd0);
    check("R4 reads stalled", log_n, 37);
    for (int k = 0; k < 10; k++) pop_check("R4 stalled read word", pack4(8'(8'h10 + 4 * k)));
    wait_irq(4'b0111);
    check("R4 done after drain", 32'(irq_status), 32'h1);
    check("R5 stop after read", 32'(log_op[41]), 32'd3);
    clr_irq(4'hF);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_write6();
    t_w1c();
    t_read5_rs();
    t_one_byte();
    t_nack();
    t_arb();
    t_overflow();
    t_rx_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule